// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and walks the memory through its mandatory start-up ritual after a synchronous reset. It owns the clock-enable, chip-select, row/column strobe, write-enable, bank and address outputs until the memory is ready, and then raises a sticky `init_done` flag. After that it only drives NOP commands with clock enable high, so the normal traffic logic can take over.

All waits are parameters counted in controller clock cycles: the stable-clock interval with clock enable low, the quiet interval before the first mode write, the mode-register spacing, the row precharge time, the refresh cycle time and the DLL lock time. The order of steps is fixed. The extended mode register is written first, with the DLL enabled. The main mode register is then written with the DLL reset bit set. A precharge of all banks follows, then a run of auto-refresh commands, and last an optional main mode write with the DLL reset bit cleared. The mode-register contents are parameters. The sequencer forces the DLL-enable bit and the DLL-reset bit itself.

Top module: `ddr_init_seq`

Cycle numbering used below: cycle 0 is the output state while reset is held. Cycle n (n ≥ 1) is the registered output state after the n-th rising edge with `rst` low. The command pins {cs_n, ras_n, cas_n, we_n} are listed in that order.

## Requirements
- R1: While `rst` is high, and in cycle 0, the outputs are cke=0, NOP (pins 0111), ba=0, addr=0 and init_done=0.
- R2: cke is 0 in cycles 0 to T_STABLE_CYC. It is 1 from cycle T_STABLE_CYC+1 onward and never falls again before reset.
- R3: Every cycle that carries no command step drives NOP: pins 0111, ba=0, addr=0.
- R4: At cycle E = T_STABLE_CYC+1+T_CKE_CYC an extended mode write is issued: pins 0000, ba=01, addr=EMRS_VALUE with bit 0 forced to 0 (DLL enabled).
- R5: At cycle M = E+T_MRD_CYC the DLL-reset mode write is issued: pins 0000, ba=00, addr=MRS_VALUE with bit 8 forced to 1.
- R6: At cycle P = M+T_MRD_CYC a precharge of all banks is issued: pins 0010, ba=0, addr has bit 10 set and all other bits 0.
- R7: N_REFRESH (at least 2) auto-refresh commands (pins 0001, ba=0, addr=0) are issued. The first comes at P+T_RP_CYC and each following one comes T_RFC_CYC cycles after the one before.
- R8: With SKIP_FINAL_MRS=0, a mode write is issued T_RFC_CYC cycles after the last refresh: pins 0000, ba=00, addr=MRS_VALUE with bit 8 forced to 0. With SKIP_FINAL_MRS=1 that slot is NOP.
- R9: init_done first goes high in cycle D = max(L+W, M+T_DLL_LOCK_CYC). Here L is the cycle of the last command, and W is T_MRD_CYC after a final mode write or T_RFC_CYC after a final refresh. It stays high, and from cycle D on only NOP is driven, with cke=1.
- R10: When the DLL lock interval ends after the last command's wait, init_done waits for the lock interval (D = M+T_DLL_LOCK_CYC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Row/column/mode address bus |
| init_done | output | 1 | High once initialization is complete; sticky until reset |

## Verification
The assertions take for granted that the only inputs are the clock and a synchronous reset, and that every wait parameter is at least one cycle with N_REFRESH at least 2. They also assume reset, once released, stays low for the whole sequence, because the sticky clock-enable and done checks rely on that. The stimulus holds reset for several cycles, releases it between clock edges and never pulses it again. Two instances are built. One has a final mode write, a short DLL lock time and a mode value with the DLL bits set wrongly on purpose. The other skips the final write and has a lock interval long enough to set the done cycle.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  // Fire operations handed from the step machine to the output stage
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_CKE_UP,
    OP_EXT_MODE,
    OP_DLL_RESET,
    OP_PRE_ALL,
    OP_REFRESH,
    OP_OP_MODE,
    OP_FINISH
  } init_op_e;

  typedef enum logic [3:0] {
    ST_CKE_LOW,
    ST_EXT_MODE,
    ST_DLL_RESET,
    ST_PRE_ALL,
    ST_REFRESH,
    ST_OP_MODE,
    ST_FINISH,
    ST_DONE
  } init_step_e;

  // Command pins in order {cs_n, ras_n, cas_n, we_n}
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_NOP  = 4'b0111;
  localparam cmd_pins_t PINS_MODE = 4'b0000;
  localparam cmd_pins_t PINS_PRE  = 4'b0010;
  localparam cmd_pins_t PINS_REF  = 4'b0001;

  // Address bit meanings that the memory decodes
  localparam int DLL_OFF_BIT  = 0;
  localparam int DLL_RST_BIT  = 8;
  localparam int ALL_BANK_BIT = 10;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int CW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CW'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  // An expired wait stays expired until a new interval is loaded
  AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero); // R9

  // A loaded interval of at least one cycle is not already expired
  AST_TIMER_LOAD_RUNS: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> !zero); // R3

endmodule

// File: rtl/init_step_fsm.sv
module init_step_fsm
  import ddr_init_pkg::*;
#(
  parameter int STEP_W         = 8,
  parameter int T_CKE_CYC      = 2,
  parameter int T_MRD_CYC      = 2,
  parameter int T_RP_CYC       = 2,
  parameter int T_RFC_CYC      = 8,
  parameter int N_REFRESH      = 2,
  parameter bit SKIP_FINAL_MRS = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_zero,
  input  logic              lock_zero,
  output init_op_e          fire_op,
  output logic              step_load,
  output logic [STEP_W-1:0] step_val,
  output logic              lock_load
);

  localparam int RC_W = $clog2(N_REFRESH + 1);

  init_step_e       state_q, state_d;
  logic [RC_W-1:0]  ref_cnt_q;
  logic             lock_armed_q;
  logic             lock_ok;
  logic             last_ref;

  assign lock_ok  = lock_armed_q && lock_zero;
  assign last_ref = (ref_cnt_q == RC_W'(N_REFRESH - 1));

  always_comb begin
    state_d   = state_q;
    fire_op   = OP_IDLE;
    step_load = 1'b0;
    step_val  = '0;
    lock_load = 1'b0;
    case (state_q)
      ST_CKE_LOW: if (step_zero) begin
        fire_op   = OP_CKE_UP;
        state_d   = ST_EXT_MODE;
        step_load = 1'b1;
        step_val  = STEP_W'(T_CKE_CYC - 1);
      end
      ST_EXT_MODE: if (step_zero) begin
        fire_op   = OP_EXT_MODE;
        state_d   = ST_DLL_RESET;
        step_load = 1'b1;
        step_val  = STEP_W'(T_MRD_CYC - 1);
      end
      ST_DLL_RESET: if (step_zero) begin
        fire_op   = OP_DLL_RESET;
        state_d   = ST_PRE_ALL;
        step_load = 1'b1;
        step_val  = STEP_W'(T_MRD_CYC - 1);
        lock_load = 1'b1;
      end
      ST_PRE_ALL: if (step_zero) begin
        fire_op   = OP_PRE_ALL;
        state_d   = ST_REFRESH;
        step_load = 1'b1;
        step_val  = STEP_W'(T_RP_CYC - 1);
      end
      ST_REFRESH: if (step_zero) begin
        fire_op   = OP_REFRESH;
        step_load = 1'b1;
        step_val  = STEP_W'(T_RFC_CYC - 1);
        if (last_ref) begin
          state_d = SKIP_FINAL_MRS ? ST_FINISH : ST_OP_MODE;
        end
      end
      ST_OP_MODE: if (step_zero) begin
        fire_op   = OP_OP_MODE;
        state_d   = ST_FINISH;
        step_load = 1'b1;
        step_val  = STEP_W'(T_MRD_CYC - 1);
      end
      ST_FINISH: if (step_zero && lock_ok) begin
        fire_op = OP_FINISH;
        state_d = ST_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_CKE_LOW;
      ref_cnt_q    <= '0;
      lock_armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (fire_op == OP_REFRESH) begin
        ref_cnt_q <= ref_cnt_q + 1'b1;
      end
      if (lock_load) begin
        lock_armed_q <= 1'b1;
      end
    end
  end

  // Past the refresh phase, exactly N_REFRESH refreshes have been fired
  AST_REFRESH_TOTAL: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OP_MODE || state_q == ST_FINISH || state_q == ST_DONE)
      |-> (ref_cnt_q == RC_W'(N_REFRESH))); // R7

  // Completion is only reached once the DLL lock interval has run out
  AST_DONE_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |-> (lock_armed_q && lock_zero)); // R10

  // The lock interval is armed exactly once, by the DLL reset write
  AST_LOCK_ARMED_ONCE: assert property (@(posedge clk) disable iff (rst)
    lock_load |-> !lock_armed_q); // R5

  // Refresh count never runs past its limit
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ref_cnt_q <= RC_W'(N_REFRESH)); // R7

endmodule

// File: rtl/init_cmd_drive.sv
module init_cmd_drive
  import ddr_init_pkg::*;
#(
  parameter int                ADDR_W     = 13,
  parameter int                BANK_W     = 2,
  parameter logic [ADDR_W-1:0] EMRS_VALUE = '0,
  parameter logic [ADDR_W-1:0] MRS_VALUE  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  init_op_e          fire_op,
  output logic              cke,
  output cmd_pins_t         pins,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  logic [ADDR_W-1:0] ext_word;
  logic [ADDR_W-1:0] dll_word;
  logic [ADDR_W-1:0] op_word;
  logic [ADDR_W-1:0] pre_word;

  always_comb begin
    ext_word               = EMRS_VALUE;
    ext_word[DLL_OFF_BIT]  = 1'b0;
    dll_word               = MRS_VALUE;
    dll_word[DLL_RST_BIT]  = 1'b1;
    op_word                = MRS_VALUE;
    op_word[DLL_RST_BIT]   = 1'b0;
    pre_word               = '0;
    pre_word[ALL_BANK_BIT] = 1'b1;
  end

  cmd_pins_t         pins_d;
  logic [BANK_W-1:0] ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    pins_d = PINS_NOP;
    ba_d   = '0;
    addr_d = '0;
    case (fire_op)
      OP_EXT_MODE: begin
        pins_d = PINS_MODE;
        ba_d   = BANK_W'(1);
        addr_d = ext_word;
      end
      OP_DLL_RESET: begin
        pins_d = PINS_MODE;
        addr_d = dll_word;
      end
      OP_PRE_ALL: begin
        pins_d = PINS_PRE;
        addr_d = pre_word;
      end
      OP_REFRESH:  pins_d = PINS_REF;
      OP_OP_MODE: begin
        pins_d = PINS_MODE;
        addr_d = op_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke  <= 1'b0;
      pins <= PINS_NOP;
      ba   <= '0;
      addr <= '0;
      done <= 1'b0;
    end else begin
      pins <= pins_d;
      ba   <= ba_d;
      addr <= addr_d;
      if (fire_op == OP_CKE_UP) cke  <= 1'b1;
      if (fire_op == OP_FINISH) done <= 1'b1;
    end
  end

  AST_CKE_STICKY: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke); // R2

  AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (rst)
    (pins != PINS_NOP) |-> cke); // R2

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R9

  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> (pins == PINS_NOP && cke)); // R9

  AST_NOP_IS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (pins == PINS_NOP) |-> (ba == '0 && addr == '0)); // R3

  AST_MODE_DLL_ON: assert property (@(posedge clk) disable iff (rst)
    (pins == PINS_MODE && ba == BANK_W'(1)) |-> !addr[DLL_OFF_BIT]); // R4

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int                ADDR_W         = 13,
  parameter int                BANK_W         = 2,
  parameter int                T_STABLE_CYC   = 20000,
  parameter int                T_CKE_CYC      = 2,
  parameter int                T_MRD_CYC      = 2,
  parameter int                T_DLL_LOCK_CYC = 200,
  parameter int                T_RP_CYC       = 2,
  parameter int                T_RFC_CYC      = 8,
  parameter int                N_REFRESH      = 2,
  parameter bit                SKIP_FINAL_MRS = 1'b0,
  parameter logic [ADDR_W-1:0] EMRS_VALUE     = '0,
  parameter logic [ADDR_W-1:0] MRS_VALUE      = 13'h0022
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int STEP_MAX = max_of(max_of(T_STABLE_CYC, T_CKE_CYC),
                                   max_of(T_MRD_CYC, max_of(T_RP_CYC, T_RFC_CYC)));
  localparam int STEP_W   = $clog2(STEP_MAX + 1);
  localparam int LOCK_W   = $clog2(T_DLL_LOCK_CYC + 1);

  generate
    if (N_REFRESH < 2) begin : g_bad_refresh
      $error("N_REFRESH must be at least 2");
    end
    if (ADDR_W <= ALL_BANK_BIT) begin : g_bad_addr
      $error("ADDR_W too narrow for the all-bank bit");
    end
  endgenerate

  init_op_e          fire_op;
  logic              step_load, step_zero;
  logic [STEP_W-1:0] step_val;
  logic              lock_load, lock_zero;
  cmd_pins_t         pins;

  init_wait_timer #(
    .CW      (STEP_W),
    .RST_VAL (T_STABLE_CYC)
  ) step_tmr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (step_load),
    .load_val (step_val),
    .zero     (step_zero)
  );

  init_wait_timer #(
    .CW      (LOCK_W),
    .RST_VAL (0)
  ) lock_tmr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (lock_load),
    .load_val (LOCK_W'(T_DLL_LOCK_CYC - 1)),
    .zero     (lock_zero)
  );

  init_step_fsm #(
    .STEP_W         (STEP_W),
    .T_CKE_CYC      (T_CKE_CYC),
    .T_MRD_CYC      (T_MRD_CYC),
    .T_RP_CYC       (T_RP_CYC),
    .T_RFC_CYC      (T_RFC_CYC),
    .N_REFRESH      (N_REFRESH),
    .SKIP_FINAL_MRS (SKIP_FINAL_MRS)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .step_zero (step_zero),
    .lock_zero (lock_zero),
    .fire_op   (fire_op),
    .step_load (step_load),
    .step_val  (step_val),
    .lock_load (lock_load)
  );

  init_cmd_drive #(
    .ADDR_W     (ADDR_W),
    .BANK_W     (BANK_W),
    .EMRS_VALUE (EMRS_VALUE),
    .MRS_VALUE  (MRS_VALUE)
  ) drive_i (
    .clk     (clk),
    .rst     (rst),
    .fire_op (fire_op),
    .cke     (cke),
    .pins    (pins),
    .ba      (ba),
    .addr    (addr),
    .done    (init_done)
  );

  assign cs_n  = pins.cs_n;
  assign ras_n = pins.ras_n;
  assign cas_n = pins.cas_n;
  assign we_n  = pins.we_n;

  // Chip select is never released during the sequence
  AST_CS_ALWAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    !cs_n); // R3

  // Clock enable rises only while a NOP is on the bus
  AST_CKE_RISE_ON_NOP: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (ras_n && cas_n && we_n)); // R2

endmodule

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb_top;

  // Configuration A: final mode write, command chain sets completion
  localparam int A_STB = 40, A_CKE = 3, A_MRD = 2, A_LCK = 20, A_RP = 3, A_RFC = 7, A_NRF = 3;
  localparam bit A_SKP = 1'b0;
  localparam logic [12:0] A_EMR = 13'h0003, A_MR = 13'h0032;
  // Configuration B: final write skipped, DLL lock sets completion
  localparam int B_STB = 25, B_CKE = 1, B_MRD = 3, B_LCK = 200, B_RP = 2, B_RFC = 4, B_NRF = 2;
  localparam bit B_SKP = 1'b1;
  localparam logic [12:0] B_EMR = 13'h0002, B_MR = 13'h0122;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0]  a_ba, b_ba;
  logic [12:0] a_addr, b_addr;

  ddr_init_seq #(
    .T_STABLE_CYC(A_STB), .T_CKE_CYC(A_CKE), .T_MRD_CYC(A_MRD), .T_DLL_LOCK_CYC(A_LCK),
    .T_RP_CYC(A_RP), .T_RFC_CYC(A_RFC), .N_REFRESH(A_NRF), .SKIP_FINAL_MRS(A_SKP),
    .EMRS_VALUE(A_EMR), .MRS_VALUE(A_MR)
  ) dut_i (
    .clk(clk), .rst(rst), .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas),
    .we_n(a_we), .ba(a_ba), .addr(a_addr), .init_done(a_done)
  );

  ddr_init_seq #(
    .T_STABLE_CYC(B_STB), .T_CKE_CYC(B_CKE), .T_MRD_CYC(B_MRD), .T_DLL_LOCK_CYC(B_LCK),
    .T_RP_CYC(B_RP), .T_RFC_CYC(B_RFC), .N_REFRESH(B_NRF), .SKIP_FINAL_MRS(B_SKP),
    .EMRS_VALUE(B_EMR), .MRS_VALUE(B_MR)
  ) dut_b_i (
    .clk(clk), .rst(rst), .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas),
    .we_n(b_we), .ba(b_ba), .addr(b_addr), .init_done(b_done)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  // Behavioural model: expected {cke, pins[3:0], ba[1:0], addr[12:0], done} in cycle n
  function automatic logic [20:0] model(input int n, input int stb, input int ckc,
      input int mrd, input int lck, input int rp, input int rfc, input int nrf,
      input bit skp, input logic [12:0] emr, input logic [12:0] mr, output string tag);
    int e, m, p, r0, rl, f, last, w, d;
    logic cke; logic [3:0] pins; logic [1:0] ba; logic [12:0] ad; logic dn;
    e = stb + 1 + ckc; m = e + mrd; p = m + mrd; r0 = p + rp;
    rl = r0 + (nrf - 1) * rfc; f = rl + rfc;
    last = skp ? rl : f;
    w = skp ? rfc : mrd;
    d = (last + w > m + lck) ? last + w : m + lck;
    cke = (n > stb); pins = 4'b0111; ba = 2'b00; ad = '0; dn = (n >= d);
    tag = "R3";
    if (n == 0) tag = "R1";
    else if (n <= stb + 1) tag = "R2";
    if (n == e) begin pins = 4'b0000; ba = 2'b01; ad = emr; ad[0] = 1'b0; tag = "R4"; end
    else if (n == m) begin pins = 4'b0000; ad = mr; ad[8] = 1'b1; tag = "R5"; end
    else if (n == p) begin pins = 4'b0010; ad[10] = 1'b1; tag = "R6"; end
    else if (n >= r0 && n <= rl && ((n - r0) % rfc) == 0) begin pins = 4'b0001; tag = "R7"; end
    else if (n == f) begin
      tag = "R8";
      if (!skp) begin pins = 4'b0000; ad = mr; ad[8] = 1'b0; end
    end
    else if (n == d) tag = (m + lck > last + w) ? "R10" : "R9";
    else if (n > d) tag = "R9";
    return {cke, pins, ba, ad, dn};
  endfunction

  task automatic compare(input string who, input int n, input logic [20:0] act,
                         input logic [20:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, who, n, act, exp);
    end
  endtask

  task automatic check_both(input int n);
    string ta, tb;
    logic [20:0] ea, eb;
    ea = model(n, A_STB, A_CKE, A_MRD, A_LCK, A_RP, A_RFC, A_NRF, A_SKP, A_EMR, A_MR, ta);
    eb = model(n, B_STB, B_CKE, B_MRD, B_LCK, B_RP, B_RFC, B_NRF, B_SKP, B_EMR, B_MR, tb);
    if (rst) begin ta = "R1"; tb = "R1"; end
    compare("cfgA", n, {a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done}, ea, ta);
    compare("cfgB", n, {b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done}, eb, tb);
  endtask

  initial begin
    // R1: reset state held over several edges
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_both(0);
    end
    rst = 1'b0;
    check_both(0);
    for (int n = 1; n <= 260; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_both(n);
    end
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule